// File: doc/BRIEF.md
# Shadow-Capture Path Delay Monitor

This block is a timing check cell for combinational paths. Each bit of a monitored combinational result goes to two registers. The main register is clocked by the system clock, and its output is also the block's normal pipeline output. The shadow register is clocked by a second clock, which is the system clock shifted by an adjustable phase. The two captured words are XORed bit by bit. On each system-clock edge the difference is sampled into a per-bit lock flag, so all lock state stays in the system clock domain.

The shadow edge comes a fixed phase after the main edge. A bit that changes in that window is seen by the shadow register but missed by the main register. Its lock flag therefore sets when the path's launch-to-arrival delay is shorter than the phase. For one test vector, a tester steps the phase upward. The first phase step at which a lock sets brackets that path's delay. About 50 ps of phase resolution is enough to resolve a single extra inverter.

An arm input decides when mismatches count. A synchronous clear empties every flag before a new phase setting or vector. When the scan enable is high, the flags form a shift chain that unloads through one serial pin. A combined flag gives a quick pass/fail result without a scan.

Top module: `skew_capture_monitor`

## Requirements
- R1: `q_out` shows the value of `path_in` captured at each rising edge of `clk`.
- R2: When armed, a lock flag sets at a `clk` edge if the main and shadow captures of that bit, as held just before the edge, differ. For a path that toggles, the flag therefore sets exactly when the path delay after the launching `clk` edge is shorter than the shadow clock's phase lag.
- R3: A set lock flag stays set through later armed cycles until a clear, a reset or a scan shift replaces it.
- R4: While `arm` is low, no lock flag becomes set, whatever the captures are.
- R5: With `clear` high, every lock flag is 0 after the next `clk` edge. `clear` wins over `scan_en` and over `arm`.
- R6: With `scan_en` high and `clear` low, the flags shift one place toward bit 0 per `clk` edge. `scan_in` enters bit WIDTH-1, and `arm` has no effect. `scan_out` always shows bit 0, so bit 0 leaves first.
- R7: `any_lock` is 1 exactly when at least one lock flag is set.
- R8: When `rst_n` is low, the main register, the shadow register and all lock flags go to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; clocks the main captures and the lock flags |
| rst_n | input | 1 | Asynchronous reset, active low |
| shadow_clk | input | 1 | Phase-shifted copy of `clk`; clocks the shadow captures |
| path_in | input | WIDTH | Outputs of the combinational paths under test |
| arm | input | 1 | Allows mismatches to set lock flags |
| clear | input | 1 | Synchronous clear of all lock flags |
| scan_en | input | 1 | Turns the lock flags into a shift chain |
| scan_in | input | 1 | Serial input into the top end of the chain |
| q_out | output | WIDTH | Main register contents |
| scan_out | output | 1 | Lock flag 0, the serial output of the chain |
| any_lock | output | 1 | OR of all lock flags |

## Verification
The bench builds the block with WIDTH = 8 at a 10 ns system period. With 8 bits, a full scan unload takes 8 cycles, so patterns can be shifted in and read back several times in one run. Chosen bits can toggle while others stay still. The bench places the path arrival and the shadow edge on integer nanoseconds within the period. This lets it sweep the phase across a fixed path delay, with the arrival on either side of the shadow edge. Every cycle, the bench predicts the lock state from its own rule and compares it through `scan_out` and `any_lock`.

// File: rtl/skew_capture_monitor.sv
module skew_capture_monitor #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shadow_clk,
  input  logic [WIDTH-1:0] path_in,
  input  logic             arm,
  input  logic             clear,
  input  logic             scan_en,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q_out,
  output logic             scan_out,
  output logic             any_lock
);

  logic [WIDTH-1:0] main_q, shadow_q, lock_q, diff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) main_q <= '0;
    else        main_q <= path_in;

  always_ff @(posedge shadow_clk or negedge rst_n)
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= path_in;

  // shadow_q crosses into the clk domain here; sampled only into lock_q
  assign diff = main_q ^ shadow_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lock_q <= '0;
    else if (clear)   lock_q <= '0;
    else if (scan_en) lock_q <= {scan_in, lock_q[WIDTH-1:1]};
    else if (arm)     lock_q <= lock_q | diff;

  assign q_out    = main_q;
  assign scan_out = lock_q[0];
  assign any_lock = |lock_q;

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !scan_en) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  assert_disarmed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !scan_en && !arm) |=> (lock_q == $past(lock_q)));

  assert_disarmed_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !scan_en && !arm) |=> !$rose(any_lock));

  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lock_q == '0 && !any_lock));

  assert_scan_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && scan_en) |=> (scan_out == $past(lock_q[1]) && lock_q[WIDTH-1] == $past(scan_in)));

endmodule

// File: tb/skew_capture_monitor_tb_top.sv
`timescale 1ns/1ps
module skew_capture_monitor_tb_top;
  localparam int W = 8;

  logic clk = 0, shadow_clk = 0, rst_n = 0;
  logic [W-1:0] path_in = '0;
  logic arm = 0, clear = 0, scan_en = 0, scan_in = 0;
  logic [W-1:0] q_out;
  logic scan_out, any_lock;

  int phi = 9, dly = 6;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [W-1:0] mlock = '0;
  logic [W-1:0] hist[$];

  skew_capture_monitor #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .shadow_clk(shadow_clk), .path_in(path_in),
    .arm(arm), .clear(clear), .scan_en(scan_en), .scan_in(scan_in),
    .q_out(q_out), .scan_out(scan_out), .any_lock(any_lock));

  always #5 clk = ~clk;

  always @(posedge clk)
    fork
      begin
        automatic int p = phi;
        #(p) shadow_clk = 1;
        #5 shadow_clk = 0;
      end
    join_none

  task automatic check(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // Called at 1 ns after a clk edge; drives one cycle and checks after the next edge.
  task automatic cycle(input logic [W-1:0] v, input logic a, input logic c,
                       input logic s, input logic si, input string rq);
    logic [W-1:0] last, mask;
    last = hist[$];
    arm = a; clear = c; scan_en = s; scan_in = si;
    mask = (dly < phi) ? (last ^ v) : '0;
    if (c)      mlock = '0;
    else if (s) mlock = {si, mlock[W-1:1]};
    else if (a) mlock = mlock | mask;
    hist.push_back(v);
    #(dly - 1) path_in = v;
    @(posedge clk); #1;
    check("R1", q_out, v);
    check({rq, "/R7"}, {{(W-1){1'b0}}, any_lock}, {{(W-1){1'b0}}, |mlock});
    check({rq, "/R6"}, {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, mlock[0]});
  endtask

  task automatic idle(input int n, input string rq);
    for (int i = 0; i < n; i++) cycle(hist[$], 0, 0, 0, 0, rq);
  endtask

  task automatic set_phase(input int p);
    phi = p;
    idle(3, "R4");
    cycle(hist[$], 0, 1, 0, 0, "R5");
  endtask

  task automatic scan_all(input logic [W-1:0] fill, input string rq);
    for (int i = 0; i < W; i++) cycle(hist[$], 1, 0, 1, fill[i], rq);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    hist.push_back('0);
    @(posedge clk); @(posedge clk); #1;
    check("R8", q_out, '0);
    check("R8", {{(W-1){1'b0}}, any_lock}, '0);
    check("R8", {{(W-1){1'b0}}, scan_out}, '0);
    rst_n = 1;
    idle(2, "R8");

    // R2: arrival 6 ns, shadow lag 9 ns -> toggling bits lock
    dly = 6; set_phase(9);
    cycle(8'h05, 1, 0, 0, 0, "R2");
    cycle(8'h05, 1, 0, 0, 0, "R3");
    cycle(8'h05, 1, 0, 0, 0, "R3");
    check("R2", {{(W-1){1'b0}}, any_lock}, 8'h01);
    scan_all(8'h00, "R6");
    check("R6", {{(W-1){1'b0}}, any_lock}, '0);

    // R2: arrival 8 ns after shadow edge at 5 ns -> no lock
    dly = 8; set_phase(5);
    cycle(8'hFF, 1, 0, 0, 0, "R2");
    cycle(8'h00, 1, 0, 0, 0, "R2");
    cycle(8'hA5, 1, 0, 0, 0, "R2");
    check("R2", {{(W-1){1'b0}}, any_lock}, '0);

    // R4: mismatches while disarmed are ignored
    dly = 4; set_phase(7);
    cycle(8'h7F, 0, 0, 0, 0, "R4");
    cycle(8'h00, 0, 0, 0, 0, "R4");
    check("R4", {{(W-1){1'b0}}, any_lock}, '0);
    cycle(8'h80, 1, 0, 0, 0, "R2");
    cycle(8'h83, 0, 0, 0, 0, "R4");
    cycle(8'h80, 0, 0, 0, 0, "R4");
    cycle(8'h80, 1, 0, 0, 0, "R3");
    cycle(8'h80, 1, 0, 0, 0, "R3");
    check("R3", {{(W-1){1'b0}}, any_lock}, 8'h01);
    scan_all(8'h69, "R6");
    scan_all(8'h00, "R6");

    // R5: clear beats scan and arm
    scan_all(8'hFF, "R6");
    cycle(8'h3C, 1, 1, 1, 1, "R5");
    check("R5", {{(W-1){1'b0}}, any_lock}, '0);
    cycle(8'h3C, 1, 0, 0, 0, "R5");
    scan_all(8'h00, "R5");

    // R2: phase sweep over a 6 ns path
    dly = 6;
    for (int k = 0; k < 4; k++) begin
      set_phase(3 + 2 * k);
      cycle(hist[$] ^ 8'h3C, 1, 0, 0, 0, "R2");
      cycle(hist[$] ^ 8'h3C, 1, 0, 0, 0, "R2");
      check("R2", {{(W-1){1'b0}}, any_lock}, {{(W-1){1'b0}}, (3 + 2 * k) > 6});
    end

    // R8: asynchronous reset mid-cycle
    #2 rst_n = 0; mlock = '0;
    #1;
    check("R8", {{(W-1){1'b0}}, any_lock}, '0);
    check("R8", q_out, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule